// File: doc/BRIEF.md
# Logical XY to frame-word address converter

This block turns a signed logical pixel coordinate into the place where that pixel lives in a frame buffer. The frame buffer is a run of 16-bit words with a 20-bit word address. Pixels are packed inside each word at 1, 2, 4, 8 or 16 bits each. For every coordinate the block returns three things: the word address, the bit offset of the pixel's field inside that word, and a 16-bit mask that covers only that field. A flag is raised when the computed address falls outside the 20-bit word space.

The layout comes from three plain configuration pins: a start word address, the number of words in one raster line, and a pixel depth code. These pins are sampled together with the coordinate at the moment it is accepted. A drawing engine feeds the block one coordinate per valid/ready handshake, and the results come back in order through a valid/ready output.

Back-pressure follows one rule. While `res_valid` is high and `res_ready` is low, the result on the output holds still and `pix_ready` is low, so no coordinate is accepted. The pipeline moves only when the output slot is empty or is being drained in that cycle.

Top module: `xy_word_mapper`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `res_valid` is 0 and `pix_ready` is 1.
- R2: With ppw = 16/depth and idx = y*width*ppw + x, where x and y are two's complement, `res_addr` is the low 20 bits of start + floor(idx/ppw).
- R3: `res_bit_off` is (idx mod ppw)*depth, counted down from bit 15, so pixel 0 of a word occupies its most significant bits.
- R4: `res_mask` has exactly `depth` ones, covering bits 15-off down to 16-off-depth, and all other bits are 0.
- R5: `res_oor` is 1 exactly when the full-precision word address (start + floor(idx/ppw)) is below 0 or above 20'hFFFFF.
- R6: `cfg_depth` codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bits per pixel. Codes 5 to 7 behave as 16 bits per pixel.
- R7: If a coordinate is accepted at rising edge n and `res_ready` is high, its result is shown with `res_valid` high after edge n+1. The block accepts one coordinate per cycle.
- R8: While `res_valid` is high and `res_ready` is low, every result output stays stable and `pix_ready` is 0. Results are never lost or duplicated, and they leave in the order the coordinates were accepted.
- R9: The configuration used for a coordinate is the one present at its acceptance edge. Changes made later do not affect that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Coordinate is valid |
| pix_ready | output | 1 | Block can accept a coordinate |
| pix_x | input | 16 | Signed X coordinate |
| pix_y | input | 16 | Signed Y coordinate |
| cfg_start | input | 20 | Start word address of the screen |
| cfg_width | input | 12 | Words per raster line |
| cfg_depth | input | 3 | Pixel depth code (see R6) |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 20 | Frame word address |
| res_bit_off | output | 4 | Field offset counted down from bit 15 |
| res_mask | output | 16 | Mask over the pixel's bits |
| res_oor | output | 1 | Address is outside the 20-bit word space |

## Verification
Each result is due on the output after the second rising edge counted from the edge that accepted its coordinate. It stays there until it is taken. The bench drives inputs at the falling edge and samples handshakes shortly before the next rising edge. At each accept it pushes a result onto an expected queue, computed from the coordinate and the configuration of that same cycle, and it pops that queue only on a cycle where a result is taken. A directed run counts the samples between acceptance and `res_valid` to pin down the latency. A stalled run checks that `pix_ready` stays low while a result is held.

// File: rtl/xyw_pkg.sv
package xyw_pkg;
  localparam int WORD_BITS = 16;
  localparam int WORD_LOG  = 4;

  // log2 of bits per pixel; codes above 4 saturate to full-word pixels
  function automatic logic [2:0] depth_log2(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

  // log2 of pixels per word
  function automatic logic [2:0] ppw_log2(input logic [2:0] code);
    return 3'(WORD_LOG) - depth_log2(code);
  endfunction
endpackage

// File: rtl/xyw_index_stage.sv
module xyw_index_stage #(
  parameter int COORD_W = 16,
  parameter int MW_W    = 12,
  parameter int ADDR_W  = 20,
  parameter int IDX_W   = COORD_W + MW_W + 6
) (
  input  logic                    clk,
  input  logic                    adv,
  input  logic [COORD_W-1:0]      x,
  input  logic [COORD_W-1:0]      y,
  input  logic [ADDR_W-1:0]       start,
  input  logic [MW_W-1:0]         width,
  input  logic [2:0]              depth,
  output logic signed [IDX_W-1:0] idx_q,
  output logic [ADDR_W-1:0]       start_q,
  output logic [2:0]              depth_q
);
  import xyw_pkg::*;

  localparam int ROW_W = MW_W + WORD_LOG + 1;

  logic [ROW_W-1:0]        row_pix;
  logic signed [IDX_W-1:0] prod;
  logic signed [IDX_W-1:0] idx_d;

  always_comb begin
    row_pix = ROW_W'(width) << ppw_log2(depth);
    prod    = IDX_W'($signed(y)) * IDX_W'($signed({1'b0, row_pix}));
    idx_d   = prod + IDX_W'($signed(x));
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      idx_q   <= idx_d;
      start_q <= start;
      depth_q <= depth;
    end
  end
endmodule

// File: rtl/xyw_place_stage.sv
module xyw_place_stage #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 34
) (
  input  logic                    clk,
  input  logic                    adv,
  input  logic signed [IDX_W-1:0] idx,
  input  logic [ADDR_W-1:0]       start,
  input  logic [2:0]              depth,
  output logic [ADDR_W-1:0]       addr_q,
  output logic [3:0]              off_q,
  output logic [15:0]             mask_q,
  output logic                    oor_q
);
  import xyw_pkg::*;

  localparam int WD_W = IDX_W + 2;

  logic [2:0]             k;
  logic [2:0]             d;
  logic signed [WD_W-1:0] word;
  logic [3:0]             sub;
  logic [3:0]             off;
  logic [4:0]             lo;
  logic [4:0]             hi;
  logic                   oor;
  logic [15:0]            mask;

  always_comb begin
    k    = ppw_log2(depth);
    d    = depth_log2(depth);
    word = WD_W'($signed({1'b0, start})) + WD_W'(idx >>> k);
    sub  = idx[3:0] & 4'((5'd1 << k) - 5'd1);
    off  = 4'(sub << d);
    hi   = 5'd15 - 5'(off);
    lo   = 5'd16 - (5'd1 << d) - 5'(off);
    oor  = word[WD_W-1] || (word[WD_W-2:ADDR_W] != '0);
  end

  for (genvar b = 0; b < WORD_BITS; b++) begin : g_mask
    assign mask[b] = (5'(b) >= lo) && (5'(b) <= hi);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      addr_q <= word[ADDR_W-1:0];
      off_q  <= off;
      mask_q <= mask;
      oor_q  <= oor;
    end
  end
endmodule

// File: rtl/xy_word_mapper.sv
module xy_word_mapper #(
  parameter int COORD_W = 16,
  parameter int MW_W    = 12,
  parameter int ADDR_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [ADDR_W-1:0]  cfg_start,
  input  logic [MW_W-1:0]    cfg_width,
  input  logic [2:0]         cfg_depth,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ADDR_W-1:0]  res_addr,
  output logic [3:0]         res_bit_off,
  output logic [15:0]        res_mask,
  output logic               res_oor
);
  localparam int IDX_W = COORD_W + MW_W + 6;

  logic                    v1;
  logic                    v2;
  logic                    adv;
  logic signed [IDX_W-1:0] idx_s1;
  logic [ADDR_W-1:0]       start_s1;
  logic [2:0]              depth_s1;

  assign adv       = !v2 || res_ready;
  assign pix_ready = adv;
  assign res_valid = v2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (adv) begin
      v1 <= pix_valid;
      v2 <= v1;
    end
  end

  xyw_index_stage #(.COORD_W(COORD_W), .MW_W(MW_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
    .clk(clk), .adv(adv), .x(pix_x), .y(pix_y), .start(cfg_start), .width(cfg_width),
    .depth(cfg_depth), .idx_q(idx_s1), .start_q(start_s1), .depth_q(depth_s1)
  );

  xyw_place_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_place (
    .clk(clk), .adv(adv), .idx(idx_s1), .start(start_s1), .depth(depth_s1),
    .addr_q(res_addr), .off_q(res_bit_off), .mask_q(res_mask), .oor_q(res_oor)
  );
endmodule

// File: rtl/xy_word_mapper_chk.sv
module xy_word_mapper_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_addr,
  input logic [3:0]        res_bit_off,
  input logic [15:0]       res_mask,
  input logic              res_oor
);
  // R1: reset empties the output slot
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !res_valid);

  // R8: a held result does not move
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) && $stable(res_bit_off)
                                   && $stable(res_mask) && $stable(res_oor)));

  // R8: no coordinate taken while stalled
  a_r8_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !pix_ready);

  // R7: a result only leaves by being taken
  a_r7_leave_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> $past(res_ready));

  // R4: mask width is a legal depth
  a_r4_mask_count: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_mask) inside {1, 2, 4, 8, 16}));

  // R4: mask is contiguous
  a_r4_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (((res_mask + (res_mask & (~res_mask + 16'd1))) & res_mask) == 16'd0));

  // R3: field starts at the reported offset below bit 15
  a_r3_mask_at_off: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (((res_mask << res_bit_off) & 16'h8000) != 16'd0));
endmodule

bind xy_word_mapper xy_word_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_addr(res_addr), .res_bit_off(res_bit_off),
  .res_mask(res_mask), .res_oor(res_oor)
);

// File: tb/xy_word_mapper_tb_top.sv
module xy_word_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [15:0] pix_x = '0;
  logic [15:0] pix_y = '0;
  logic [19:0] cfg_start = '0;
  logic [11:0] cfg_width = 12'd1;
  logic [2:0]  cfg_depth = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [19:0] res_addr;
  logic [3:0]  res_bit_off;
  logic [15:0] res_mask;
  logic        res_oor;

  typedef struct packed {
    logic [19:0] addr;
    logic [3:0]  off;
    logic [15:0] mask;
    logic        oor;
  } exp_t;

  int   checks = 0;
  int   fails  = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  xy_word_mapper dut_i (.*);

  function automatic exp_t model(input logic [15:0] x, input logic [15:0] y,
                                 input logic [19:0] st, input logic [11:0] mw,
                                 input logic [2:0] code);
    exp_t   e;
    int     dl = (code > 3'd4) ? 4 : int'(code);   // R6
    longint dep = longint'(1) << dl;
    longint ppw = 16 / dep;
    longint idx = longint'($signed(y)) * longint'(mw) * ppw + longint'($signed(x));
    longint wrd = longint'(st) + (idx >>> (4 - dl));
    longint sub = idx & (ppw - 1);
    longint off = sub * dep;
    e.addr = wrd[19:0];
    e.off  = off[3:0];
    e.mask = 16'(((longint'(1) << dep) - 1) << (16 - dep - off));
    e.oor  = (wrd < 0) || (wrd > 64'hFFFFF);
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sample handshakes just before the rising edge, then move to the next falling edge.
  task automatic cycle(output bit vis);
    #8;
    vis = res_valid;
    if (res_valid && res_ready) begin
      if (q.size() == 0) check(1'b0, "R8 unexpected result", 1, 0);
      else begin
        exp_t e = q.pop_front();
        check(res_addr == e.addr, "R2 addr", res_addr, e.addr);
        check(res_bit_off == e.off, "R3 bit offset", res_bit_off, e.off);
        check(res_mask == e.mask, "R4 mask", res_mask, e.mask);
        check(res_oor == e.oor, "R5 out of range", res_oor, e.oor);
      end
    end
    if (pix_valid && pix_ready) q.push_back(model(pix_x, pix_y, cfg_start, cfg_width, cfg_depth));
    @(negedge clk);
  endtask

  task automatic put(input logic [15:0] x, input logic [15:0] y, input logic [19:0] st,
                     input logic [11:0] mw, input logic [2:0] dc);
    bit v;
    pix_valid = 1'b1; pix_x = x; pix_y = y; cfg_start = st; cfg_width = mw; cfg_depth = dc;
    cycle(v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit v;
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: idle during reset
    #8;
    check(res_valid == 1'b0 && pix_ready == 1'b1, "R1 in reset", {res_valid, pix_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    #8;
    check(res_valid == 1'b0 && pix_ready == 1'b1, "R1 after release", {res_valid, pix_ready}, 2'b01);
    @(negedge clk);

    // R7: latency of two edges
    put(16'd5, 16'd2, 20'h00100, 12'd10, 3'd2);
    pix_valid = 1'b0;
    cycle(v);
    check(v == 1'b0, "R7 early valid", v, 0);
    cycle(v);
    check(v == 1'b1, "R7 valid after second edge", v, 1);

    // R3/R4 corners at 1 bpp: pixel 0 in MSB, pixel 15 in LSB
    put(16'd0, 16'd0, 20'h00000, 12'd4, 3'd0);
    put(16'd15, 16'd0, 20'h00000, 12'd4, 3'd0);
    put(16'd3, 16'd1, 20'h00040, 12'd4, 3'd2);         // 4 bpp last field
    put(16'd7, 16'd3, 20'h12345, 12'd80, 3'd4);        // 16 bpp full mask
    put(16'd9, 16'd1, 20'h00010, 12'd8, 3'd7);         // R6 code 7 as 16 bpp
    put(16'd9, 16'd1, 20'h00010, 12'd8, 3'd5);         // R6 code 5 as 16 bpp
    put(16'hFFFF, 16'd0, 20'h00000, 12'd4, 3'd3);      // R5 below zero
    put(16'd16, 16'd0, 20'hFFFFF, 12'd4, 3'd4);        // R5 past top
    put(16'd0, 16'd0, 20'hFFFFF, 12'd4, 3'd4);         // R5 exactly top, in range
    put(16'hFFFD, 16'hFFFF, 20'h80000, 12'd100, 3'd1); // R2 negative x and y
    // R9: config changes right after acceptance
    put(16'd6, 16'd6, 20'h00200, 12'd20, 3'd1);
    pix_valid = 1'b0; cfg_start = 20'hABCDE; cfg_width = 12'd1; cfg_depth = 3'd4;
    repeat (4) cycle(v);
    check(q.size() == 0, "R9 directed drained", q.size(), 0);

    // R8: stall holds pix_ready low
    res_ready = 1'b0;
    put(16'd1, 16'd1, 20'h00300, 12'd2, 3'd0);
    put(16'd2, 16'd1, 20'h00300, 12'd2, 3'd0);
    pix_valid = 1'b0;
    repeat (3) cycle(v);
    #1;
    check(res_valid && !pix_ready, "R8 stalled not ready", {res_valid, pix_ready}, 2'b10);
    @(negedge clk);
    res_ready = 1'b1;
    repeat (4) cycle(v);
    check(q.size() == 0, "R8 stalled items delivered", q.size(), 0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      pix_valid = ($urandom % 10) < 7;
      res_ready = ($urandom % 10) < 7;
      pix_x     = 16'($urandom);
      pix_y     = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 600);
      cfg_start = 20'($urandom);
      cfg_width = 12'($urandom);
      cfg_depth = 3'($urandom % 8);
      cycle(v);
    end
    pix_valid = 1'b0;
    res_ready = 1'b1;
    repeat (6) cycle(v);
    check(q.size() == 0, "R8 no loss after random run", q.size(), 0);
    finish_run();
  end
endmodule